// File: doc/BRIEF.md
# Half-Duplex Turnaround Guard Timer

This block governs the direction of a single-wire, half-duplex serial link. In receive mode the local driver is off. When the link owner asks to transmit, the block turns the driver on and holds the line at its idle (high) level. It keeps it there for a programmable number of bit periods. Only then does it signal that transmission may begin. The return from transmit to receive is immediate and adds no delay.

The length of the idle gap comes from a 3-bit guard code. Each code below all-ones halves the gap of the previous code, starting from 128 extra bits at code 000. Code 111 adds nothing. Two fixed idle bits are always added on top. Idle bits are counted on an external bit-period tick. The code is taken at the moment the turnaround starts, so it may be rewritten freely during a count.

Top module: `turnaround_guard`

## Requirements
- R1: The guard code selects the extra idle bits as 000→128, 001→64, 010→32, 011→16, 100→8, 101→4, 110→2 and 111→0, meaning 2^(7−code) for codes 0 to 6 and zero for code 7.
- R2: In a receive-to-transmit turnaround, `tx_ready` rises on the clock edge that samples the (extra + 2)-th `bit_tick` of the count, and not earlier.
- R3: While the idle count runs, `drive_en` and `line_idle` are 1 and `tx_ready` is 0.
- R4: Once set, `tx_ready` stays 1 until `rx_req` is seen. Ticks and further `tx_req` pulses in transmit mode have no effect.
- R5: An `rx_req` in transmit mode clears `drive_en` and `tx_ready` on the next clock edge, with no inserted delay.
- R6: The guard code is captured on the edge that starts the turnaround. A change made during the count applies only from the next turnaround.
- R7: An `rx_req` during the count aborts it on the next edge: all outputs go to 0, and later ticks do not raise `tx_ready`. A new turnaround counts the full gap again.
- R8: A synchronous active-high reset puts the block in receive mode with `drive_en`, `tx_ready` and `line_idle` all at 0.
- R9: Ticks are counted only in the guard phase. A tick in receive mode, or in the same cycle as the starting `tx_req`, is not counted. When `tx_req` and `rx_req` arrive together in receive mode, the block stays in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_req | input | 1 | Request to change to transmit |
| rx_req | input | 1 | Request to change to receive |
| guard_code | input | 3 | Guard-time code |
| drive_en | output | 1 | Local driver enabled (registered) |
| tx_ready | output | 1 | Transmission may start (registered) |
| line_idle | output | 1 | Driver holding idle level during guard count (registered) |

## Verification
The checker assumes that `bit_tick` is a single-cycle pulse and that requests are level samples taken at each edge. It also assumes that the count of ticks seen while `line_idle` is high restarts each time `line_idle` falls. This holds because the stimulus raises each tick for exactly one cycle with an idle cycle after it, and drives every request for one cycle on the falling clock edge. The expected gap is latched from `guard_code` under the same start condition the ports imply: receive mode, `tx_req` high and `rx_req` low. The bench therefore changes the code only after a start, so the latched value is unambiguous.

// File: rtl/turn_pkg.sv
package turn_pkg;

  typedef enum logic [1:0] {
    ST_RX    = 2'd0,
    ST_GUARD = 2'd1,
    ST_TX    = 2'd2
  } turn_state_e;

endpackage

// File: rtl/turn_guard_decode.sv
// Maps the guard code to an idle-bit total: exponential extra part plus fixed bits.
module turn_guard_decode #(
  parameter int CODE_W     = 3,
  parameter int FIXED_IDLE = 2,
  parameter int CNT_W      = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  total
);

  localparam int TOP_SHIFT = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] extra;

  always_comb begin
    if (code == {CODE_W{1'b1}}) begin
      extra = '0;
    end else begin
      extra = CNT_W'(1) << (TOP_SHIFT - int'(code));
    end
    total = extra + CNT_W'(FIXED_IDLE);
  end

endmodule

// File: rtl/turn_idle_counter.sv
// Down-counter of remaining idle bits; loaded at turnaround start.
module turn_idle_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && remain_q != '0) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign last = (remain_q == CNT_W'(1));

endmodule

// File: rtl/turn_fsm.sv
// Direction state machine with registered outputs.
module turn_fsm
  import turn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_req,
  input  logic rx_req,
  input  logic cnt_last,
  output logic cnt_load,
  output logic cnt_dec,
  output logic cnt_clear,
  output logic drive_en,
  output logic tx_ready,
  output logic line_idle
);

  turn_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_clear = 1'b0;
    unique case (state_q)
      ST_RX: begin
        if (tx_req && !rx_req) begin
          state_d  = ST_GUARD;
          cnt_load = 1'b1;
        end
      end
      ST_GUARD: begin
        if (rx_req) begin
          state_d   = ST_RX;
          cnt_clear = 1'b1;
        end else if (bit_tick) begin
          cnt_dec = 1'b1;
          if (cnt_last) begin
            state_d = ST_TX;
          end
        end
      end
      ST_TX: begin
        if (rx_req) begin
          state_d = ST_RX;
        end
      end
      default: begin
        state_d   = ST_RX;
        cnt_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RX;
      drive_en  <= 1'b0;
      tx_ready  <= 1'b0;
      line_idle <= 1'b0;
    end else begin
      state_q   <= state_d;
      drive_en  <= (state_d != ST_RX);
      tx_ready  <= (state_d == ST_TX);
      line_idle <= (state_d == ST_GUARD);
    end
  end

endmodule

// File: rtl/turnaround_guard.sv
module turnaround_guard #(
  parameter int CODE_W     = 3,
  parameter int FIXED_IDLE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_req,
  input  logic              rx_req,
  input  logic [CODE_W-1:0] guard_code,
  output logic              drive_en,
  output logic              tx_ready,
  output logic              line_idle
);

  localparam int MAX_EXTRA = 1 << ((1 << CODE_W) - 1);
  localparam int CNT_W     = $clog2(MAX_EXTRA + FIXED_IDLE + 1);

  logic [CNT_W-1:0] idle_total;
  logic             cnt_load, cnt_dec, cnt_clear, cnt_last;

  turn_guard_decode #(
    .CODE_W    (CODE_W),
    .FIXED_IDLE(FIXED_IDLE),
    .CNT_W     (CNT_W)
  ) u_decode (
    .code (guard_code),
    .total(idle_total)
  );

  turn_idle_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .clear   (cnt_clear),
    .load    (cnt_load),
    .load_val(idle_total),
    .dec     (cnt_dec),
    .last    (cnt_last)
  );

  turn_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .tx_req   (tx_req),
    .rx_req   (rx_req),
    .cnt_last (cnt_last),
    .cnt_load (cnt_load),
    .cnt_dec  (cnt_dec),
    .cnt_clear(cnt_clear),
    .drive_en (drive_en),
    .tx_ready (tx_ready),
    .line_idle(line_idle)
  );

endmodule

// File: rtl/turn_guard_checker.sv
module turn_guard_checker #(
  parameter int CODE_W     = 3,
  parameter int FIXED_IDLE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              tx_req,
  input logic              rx_req,
  input logic [CODE_W-1:0] guard_code,
  input logic              drive_en,
  input logic              tx_ready,
  input logic              line_idle
);

  int exp_total;
  int ticks_seen;

  // Expected gap latched at the start condition seen on the ports (R1, R6).
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_total <= 0;
    end else if (!drive_en && tx_req && !rx_req) begin
      if (guard_code == {CODE_W{1'b1}}) exp_total <= FIXED_IDLE;
      else exp_total <= (2 ** ((2 ** CODE_W) - 1 - int'(guard_code))) + FIXED_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !line_idle) ticks_seen <= 0;
    else if (bit_tick) ticks_seen <= ticks_seen + 1;
  end

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!drive_en && !tx_ready && !line_idle));

  p_gap_length_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> (ticks_seen == exp_total));

  p_ready_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> ($past(line_idle) && $past(bit_tick)));

  p_guard_levels_r3: assert property (@(posedge clk) disable iff (rst)
    line_idle |-> (drive_en && !tx_ready));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !rx_req) |=> tx_ready);

  p_tx_release_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && rx_req) |=> (!drive_en && !tx_ready));

  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (line_idle && rx_req) |=> (!drive_en && !line_idle && !tx_ready));

  p_rx_priority_r9: assert property (@(posedge clk) disable iff (rst)
    (!drive_en && rx_req) |=> !drive_en);

endmodule

bind turnaround_guard turn_guard_checker #(
  .CODE_W    (CODE_W),
  .FIXED_IDLE(FIXED_IDLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_tick  (bit_tick),
  .tx_req    (tx_req),
  .rx_req    (rx_req),
  .guard_code(guard_code),
  .drive_en  (drive_en),
  .tx_ready  (tx_ready),
  .line_idle (line_idle)
);

// File: tb/tb_turnaround_guard.sv
`timescale 1ns/1ps
module tb_turnaround_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       tx_req = 1'b0;
  logic       rx_req = 1'b0;
  logic [2:0] guard_code = 3'd0;
  logic       drive_en, tx_ready, line_idle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  turnaround_guard dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_req(tx_req),
    .rx_req(rx_req), .guard_code(guard_code), .drive_en(drive_en),
    .tx_ready(tx_ready), .line_idle(line_idle)
  );

  function automatic int gap_of(input int code);
    if (code == 7) return 2;
    return (1 << (7 - code)) + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input bit de, input bit tr, input bit li);
    check(drive_en == de && tx_ready == tr && line_idle == li, req,
          {drive_en, tx_ready, line_idle}, {de, tr, li});
  endtask

  task automatic start_tx();
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
  endtask

  task automatic go_rx();
    @(negedge clk) rx_req = 1'b1;
    @(negedge clk) rx_req = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  // Ticks until tx_ready rises; checks guard levels on the way (R3).
  task automatic measure(output int n);
    n = 0;
    while (!tx_ready && n < 300) begin
      pulse_tick();
      n++;
      if (!tx_ready) check_outs("R3 guard levels", 1'b1, 1'b0, 1'b1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_outs("R8 reset outputs", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R8 after reset release", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sweep();
    int n;
    for (int c = 0; c < 8; c++) begin
      guard_code = 3'(c);
      start_tx();
      check_outs("R3 guard entered", 1'b1, 1'b0, 1'b1);
      measure(n);
      check(n == gap_of(c), "R1 R2 gap length", n, gap_of(c));
      check_outs("R2 ready state", 1'b1, 1'b1, 1'b0);
      go_rx();
      check_outs("R5 back to receive", 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_hold();
    guard_code = 3'd6;
    start_tx();
    begin int n; measure(n); end
    start_tx();
    repeat (5) pulse_tick();
    check_outs("R4 ready held", 1'b1, 1'b1, 1'b0);
    @(negedge clk) rx_req = 1'b1;
    @(negedge clk) rx_req = 1'b0;
    check_outs("R5 release next edge", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_code_change();
    int n;
    guard_code = 3'd6;
    start_tx();
    guard_code = 3'd0;
    pulse_tick();
    guard_code = 3'd5;
    measure(n);
    check(n + 1 == gap_of(6), "R6 code held during count", n + 1, gap_of(6));
    go_rx();
    start_tx();
    measure(n);
    check(n == gap_of(5), "R6 new code next turnaround", n, gap_of(5));
    go_rx();
  endtask

  task automatic t_abort();
    int n;
    guard_code = 3'd3;
    start_tx();
    repeat (10) pulse_tick();
    check_outs("R7 still counting", 1'b1, 1'b0, 1'b1);
    go_rx();
    check_outs("R7 abort outputs", 1'b0, 1'b0, 1'b0);
    repeat (20) pulse_tick();
    check_outs("R7 no ready after abort", 1'b0, 1'b0, 1'b0);
    start_tx();
    measure(n);
    check(n == gap_of(3), "R7 full gap after abort", n, gap_of(3));
    go_rx();
  endtask

  task automatic t_rx_ticks();
    int n;
    guard_code = 3'd7;
    repeat (5) pulse_tick();
    check_outs("R9 ticks ignored in receive", 1'b0, 1'b0, 1'b0);
    @(negedge clk) begin tx_req = 1'b1; rx_req = 1'b1; end
    @(negedge clk) begin tx_req = 1'b0; rx_req = 1'b0; end
    check_outs("R9 receive wins", 1'b0, 1'b0, 1'b0);
    @(negedge clk) begin tx_req = 1'b1; bit_tick = 1'b1; end
    @(negedge clk) begin tx_req = 1'b0; bit_tick = 1'b0; end
    measure(n);
    check(n == gap_of(7), "R9 start tick not counted", n, gap_of(7));
    go_rx();
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_code_change();
    t_abort();
    t_rx_ticks();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule